// File: doc/BRIEF.md
# Real-Time Clock Counter with Alarm Wake

This block is the register side of a battery-backed real-time clock. A 48-bit time counter advances by one on every pulse of `tick_i`, which stands in for the low-frequency oscillator. The tick runs at twice the 32768 Hz crystal rate, so 65536 counts make one second. Software loads the time one byte at a time over a byte-wide register bus. It then sets a sticky valid flag that survives everything except a power-loss reset.

A 32-bit alarm value is compared against the upper 32 bits of the counter, which gives the alarm a resolution of one second. When the alarm is enabled and a tick brings the counter's upper part to the alarm value, the block emits a single-cycle wake request for the power sequencer. It raises no interrupt. Reads are registered. A read of the lowest counter byte freezes a shadow copy of the whole counter, so the five bytes read after it belong to the same instant.

Top module: `rtc_alarm_regs`

## Requirements
- R1: While `rst_ni` is low and after it rises, the counter and alarm are 0, the control register reads 0x30 with the valid bit (bit 0) at 0, `wake_o` is 0 and `rdata_o` is 0.
- R2: Each cycle with `tick_i` high and no counter write adds one to the 48-bit counter, with carry across bytes, and wraps from all ones to 0. Without a tick and without a counter write, the counter holds.
- R3: A write to address 0x5A+i (i = 0..5, i = 0 is the least significant byte) replaces only counter byte i, effective at the next edge. A tick in the same cycle is dropped.
- R4: The control register is at 0x53. A write of 1 to bit 0 (time valid) sets it, and later writes of 0 leave it at 1 until reset.
- R5: Control bits 7..1 take the written value. `osc_bypass_o` follows bit 1, `clk_buf_dis_o` follows bit 3 and bit 2 is alarm enable.
- R6: The alarm bytes are at 0x56..0x59, least significant first, and read back as written. They match counter bits 47..16, and counter bits 15..0 play no part in the match.
- R7: When bit 2 is 1, `wake_o` is high for exactly the one cycle after the tick edge at which counter bits 47..16 change from unequal to equal to the alarm. When bit 2 is 0, no wake is raised.
- R8: A read of 0x5A returns the live byte 0 and latches all six counter bytes into a shadow copy. Reads of 0x5B..0x5F return that shadow copy, so writes or ticks after the latch do not show.
- R9: `rdata_o` is loaded at the clock edge where `re_i` is high and holds its value while `re_i` is low.
- R10: Reads of any address outside 0x53, 0x56..0x59 and 0x5A..0x5F return 0x00. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Active-low asynchronous power-loss reset |
| tick_i | input | 1 | Count enable, one pulse per counter increment |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| wake_o | output | 1 | Single-cycle alarm wake request |
| osc_bypass_o | output | 1 | Oscillator bypass control (control bit 1) |
| clk_buf_dis_o | output | 1 | Clock buffer disable control (control bit 3) |

## Verification
The bench builds the block with its default parameters: a 48-bit counter, a 32-bit alarm, byte-wide data and the address map above. With these values, loading the counter directly next to a 16-bit boundary or next to all ones brings the carry into the compared upper bits, the full wrap and the alarm edge within a handful of ticks. No long counting run is needed. The same loads show whether the wake fires only on the first matching tick, and whether the low 16 bits stay out of the match.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 48;
  localparam int ALM_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h53;
  localparam logic [ADDR_W-1:0] ALM_BASE  = 8'h56;
  localparam logic [ADDR_W-1:0] CNT_BASE  = 8'h5A;
  localparam logic [BYTE_W-1:0] CTRL_RST  = 8'h30;

  // control bit positions
  localparam int CB_VALID = 0;
  localparam int CB_BYP   = 1;
  localparam int CB_ALMEN = 2;
  localparam int CB_BUFD  = 3;
endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
  parameter int CNT_W  = 48,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NB-1:0]     wr_sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              snap_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  nxt_o,
  output logic [CNT_W-1:0]  shadow_o,
  output logic              adv_o
);
  logic [CNT_W-1:0] cnt_q, shd_q, nxt;
  logic adv;

  // byte writes win over the tick
  always_comb begin
    nxt = cnt_q;
    adv = 1'b0;
    if (|wr_sel_i) begin
      for (int i = 0; i < NB; i++)
        if (wr_sel_i[i]) nxt[i*BYTE_W +: BYTE_W] = wdata_i;
    end else if (tick_i) begin
      nxt = cnt_q + CNT_W'(1);
      adv = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      shd_q <= '0;
    end else begin
      cnt_q <= nxt;
      if (snap_i) shd_q <= cnt_q;
    end
  end

  assign cnt_o    = cnt_q;
  assign nxt_o    = nxt;
  assign shadow_o = shd_q;
  assign adv_o    = adv;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int CNT_W  = 48,
  parameter int ALM_W  = 32,
  parameter int BYTE_W = 8,
  localparam int NB    = ALM_W / BYTE_W,
  localparam int LSB   = CNT_W - ALM_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB-1:0]     wr_sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  nxt_i,
  output logic [ALM_W-1:0]  alm_o,
  output logic              wake_o
);
  logic [BYTE_W-1:0] alm_b [NB];
  logic [ALM_W-1:0]  alm_w;
  logic hit_cur, hit_nxt, wake_q;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          alm_b[g] <= '0;
      else if (wr_sel_i[g]) alm_b[g] <= wdata_i;
    end
    assign alm_w[g*BYTE_W +: BYTE_W] = alm_b[g];
  end

  assign hit_cur = (cnt_i[CNT_W-1:LSB] == alm_w);
  assign hit_nxt = (nxt_i[CNT_W-1:LSB] == alm_w);

  // fire only on the tick that first reaches the match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= en_i & adv_i & hit_nxt & ~hit_cur;
  end

  assign alm_o  = alm_w;
  assign wake_o = wake_q;
endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_pkg::*;
#(
  parameter int                DW  = BYTE_W,
  parameter logic [BYTE_W-1:0] RST = CTRL_RST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl_o
);
  logic [DW-1:0] ctrl_q;

  // valid bit is set-only; cleared by power-loss reset alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= DW'(RST);
    else if (wr_i) ctrl_q <= {wdata_i[DW-1:1], ctrl_q[CB_VALID] | wdata_i[CB_VALID]};
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_pkg::*;
#(
  parameter int                CW     = CNT_W,
  parameter int                AW     = ALM_W,
  parameter int                DW     = BYTE_W,
  parameter int                ADW    = ADDR_W,
  parameter logic [ADDR_W-1:0] A_CTRL = CTRL_ADDR,
  parameter logic [ADDR_W-1:0] A_ALM  = ALM_BASE,
  parameter logic [ADDR_W-1:0] A_CNT  = CNT_BASE
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [ADW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           we_i,
  input  logic           re_i,
  output logic [DW-1:0]  rdata_o,
  output logic           wake_o,
  output logic           osc_bypass_o,
  output logic           clk_buf_dis_o
);
  localparam int CNB = CW / DW;
  localparam int ANB = AW / DW;

  logic [CNB-1:0] cnt_hit, cnt_sel;
  logic [ANB-1:0] alm_hit, alm_sel;
  logic           ctrl_hit;
  logic [CW-1:0]  cnt_q, cnt_nxt, cnt_shd;
  logic [AW-1:0]  alm_q;
  logic [DW-1:0]  ctrl_q, rd_nxt, rdata_q;
  logic           adv;

  assign ctrl_hit = (addr_i == A_CTRL);
  for (genvar g = 0; g < CNB; g++) begin : g_cdec
    assign cnt_hit[g] = (addr_i == ADW'(A_CNT + g));
  end
  for (genvar g = 0; g < ANB; g++) begin : g_adec
    assign alm_hit[g] = (addr_i == ADW'(A_ALM + g));
  end
  assign cnt_sel = cnt_hit & {CNB{we_i}};
  assign alm_sel = alm_hit & {ANB{we_i}};

  rtc_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i & ctrl_hit),
    .wdata_i(wdata_i),
    .ctrl_o (ctrl_q)
  );

  rtc_time_counter #(.CNT_W(CW), .BYTE_W(DW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wr_sel_i(cnt_sel),
    .wdata_i (wdata_i),
    .snap_i  (re_i & cnt_hit[0]),
    .cnt_o   (cnt_q),
    .nxt_o   (cnt_nxt),
    .shadow_o(cnt_shd),
    .adv_o   (adv)
  );

  rtc_alarm_cmp #(.CNT_W(CW), .ALM_W(AW), .BYTE_W(DW)) u_alm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_sel_i(alm_sel),
    .wdata_i (wdata_i),
    .en_i    (ctrl_q[CB_ALMEN]),
    .adv_i   (adv),
    .cnt_i   (cnt_q),
    .nxt_i   (cnt_nxt),
    .alm_o   (alm_q),
    .wake_o  (wake_o)
  );

  // read mux: byte 0 live, upper counter bytes from shadow
  always_comb begin
    rd_nxt = '0;
    if (ctrl_hit) rd_nxt = ctrl_q;
    for (int i = 0; i < ANB; i++)
      if (alm_hit[i]) rd_nxt = alm_q[i*DW +: DW];
    for (int i = 0; i < CNB; i++)
      if (cnt_hit[i]) rd_nxt = (i == 0) ? cnt_q[DW-1:0] : cnt_shd[i*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_nxt;
  end

  assign rdata_o       = rdata_q;
  assign osc_bypass_o  = ctrl_q[CB_BYP];
  assign clk_buf_dis_o = ctrl_q[CB_BUFD];
endmodule

// File: rtl/rtc_alarm_regs_chk.sv
module rtc_alarm_regs_chk
  import rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              wake_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [BYTE_W-1:0] ctrl_q
);
  logic cnt_wr, mapped;
  assign cnt_wr = we_i && (addr_i >= CNT_BASE) && (addr_i <= CNT_BASE + 8'd5);
  assign mapped = (addr_i == CTRL_ADDR) ||
                  ((addr_i >= ALM_BASE) && (addr_i <= CNT_BASE + 8'd5));

  a_r2_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !cnt_wr) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_wr) |=> $stable(cnt_q));

  a_r4_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CB_VALID] |=> ctrl_q[CB_VALID]);

  a_r7_wake_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(ctrl_q[CB_ALMEN]));

  a_r7_wake_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(tick_i));

  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !mapped) |=> rdata_o == '0);

  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

bind rtc_alarm_regs rtc_alarm_regs_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .we_i   (we_i),
  .re_i   (re_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .wake_o (wake_o),
  .cnt_q  (cnt_q),
  .ctrl_q (ctrl_q)
);

// File: tb/sim_rtc_alarm_regs.sv
module sim_rtc_alarm_regs;
  localparam int CLK_P = 10;
  localparam int NV = 16;
  // {req[3:0], is_write, addr, data, expected}
  localparam logic [28:0] VEC [NV] = '{
    {4'd1,  1'b0, 8'h53, 8'h00, 8'h30},  // R1 ctrl reset
    {4'd1,  1'b0, 8'h5F, 8'h00, 8'h00},  // R1 counter reset
    {4'd6,  1'b1, 8'h56, 8'h11, 8'h00},  // R6
    {4'd6,  1'b1, 8'h59, 8'h44, 8'h00},
    {4'd6,  1'b0, 8'h56, 8'h00, 8'h11},
    {4'd6,  1'b0, 8'h59, 8'h00, 8'h44},
    {4'd5,  1'b1, 8'h53, 8'h0B, 8'h00},  // R5
    {4'd5,  1'b0, 8'h53, 8'h00, 8'h0B},
    {4'd4,  1'b1, 8'h53, 8'h00, 8'h00},  // R4 try to clear valid
    {4'd4,  1'b0, 8'h53, 8'h00, 8'h01},
    {4'd10, 1'b1, 8'h40, 8'hAA, 8'h00},  // R10
    {4'd10, 1'b0, 8'h40, 8'h00, 8'h00},
    {4'd3,  1'b1, 8'h5C, 8'h77, 8'h00},  // R3
    {4'd8,  1'b0, 8'h5A, 8'h00, 8'h00},  // R8 latch
    {4'd3,  1'b0, 8'h5C, 8'h00, 8'h77},
    {4'd10, 1'b0, 8'h55, 8'h00, 8'h00}
  };

  logic clk = 0, rst_n = 0, tick = 0, we = 0, re = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic wake, byp, bufd;
  int errs = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_alarm_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .wake_o(wake),
    .osc_bypass_o(byp), .clk_buf_dis_o(bufd)
  );

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    @(negedge clk); re = 1; addr = a;
    @(negedge clk); re = 0; v = rdata;
  endtask

  task automatic rd_cnt(output logic [47:0] v);
    logic [7:0] b;
    for (int i = 0; i < 6; i++) begin
      rd(8'h5A + 8'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic ld_cnt(logic [47:0] v);
    for (int i = 0; i < 6; i++) wr(8'h5A + 8'(i), v[i*8 +: 8]);
  endtask

  task automatic tick_n(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [47:0] c;
    repeat (3) @(negedge clk);
    chk("R1 wake", 48'(wake), 48'd0);
    chk("R1 rdata", 48'(rdata), 48'd0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        wr(VEC[i][23:16], VEC[i][15:8]);
        if (i == 6) begin
          chk("R5 bypass out", 48'(byp), 48'd1);
          chk("R5 bufdis out", 48'(bufd), 48'd1);
        end
      end else begin
        rd(VEC[i][23:16], v);
        chk($sformatf("R%0d vec%0d", VEC[i][28:25], i), 48'(v), 48'(VEC[i][7:0]));
      end
    end

    // R2 counting, carry, wrap
    ld_cnt(48'h0);
    tick_n(5);
    rd_cnt(c); chk("R2 five ticks", c, 48'd5);
    ld_cnt(48'h0000_0000_FFFF);
    tick_n(1);
    rd_cnt(c); chk("R2 carry", c, 48'h0000_0001_0000);
    ld_cnt(48'hFFFF_FFFF_FFFF);
    tick_n(1);
    rd_cnt(c); chk("R2 wrap", c, 48'h0);

    // R3 write beats simultaneous tick
    @(negedge clk); tick = 1; we = 1; addr = 8'h5A; wdata = 8'h10;
    @(negedge clk); tick = 0; we = 0;
    rd_cnt(c); chk("R3 write wins", c, 48'h10);

    // R8 shadow coherence
    rd(8'h5A, v);
    wr(8'h5B, 8'h99);
    rd(8'h5B, v); chk("R8 shadow old", 48'(v), 48'h00);
    rd(8'h5A, v);
    rd(8'h5B, v); chk("R8 shadow new", 48'(v), 48'h99);

    // R9 hold while idle
    @(negedge clk); addr = 8'h53;
    @(negedge clk); chk("R9 hold", 48'(rdata), 48'h99);

    // R7 wake on first match, alarm enabled
    wr(8'h56, 8'h02); wr(8'h57, 8'h00); wr(8'h58, 8'h00); wr(8'h59, 8'h00);
    wr(8'h53, 8'h05);
    ld_cnt(48'h0000_0001_FFFE);
    tick_n(1); chk("R6 low bits no match", 48'(wake), 48'd0);
    tick_n(1); chk("R7 wake pulse", 48'(wake), 48'd1);
    @(negedge clk); chk("R7 one cycle", 48'(wake), 48'd0);
    tick_n(3); chk("R7 no refire", 48'(wake), 48'd0);

    // R7 disabled
    wr(8'h53, 8'h01);
    ld_cnt(48'h0000_0001_FFFF);
    tick_n(1); chk("R7 disabled", 48'(wake), 48'd0);
    rd(8'h53, v); chk("R4 still valid", 48'(v), 48'h01);

    finish_run();
  end
endmodule